// File: doc/BRIEF.md
# Pattern Memory Test Sequencer

This block exercises a 16-bit-wide memory across an address window given by an inclusive start and end byte address. It runs a fixed series of test patterns. Each pattern gets a write sweep over the whole window, and only after that a read sweep over the same window. Every word that is read back is compared with the pattern that was written. A mismatch increments an error counter and records the failing address, the word that came back and the word that was expected. A later failure overwrites an earlier one.

Software or a boot controller presents the window and pulses `start_i`. The engine then owns the memory port until it pulses `done_o`, and the caller reads the error count and the last-failure record. The memory port is a plain synchronous one: a request with a write enable, a byte address and write data. Read data returns one clock after a read request. Both window addresses must be word aligned and the start must not exceed the end.

Top module: `mem_pattern_tester`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o` and `mem_req_o` are low, and the error count and all three failure-record outputs are zero.
- R2: For each pattern the engine first issues one write (`mem_we_o`=1) per word, at ascending addresses from the start address to the end address in steps of 2. It then issues one read (`mem_we_o`=0) per word over the same addresses in the same order. No cycle without a request falls inside a run.
- R3: The patterns run in this order, 36 passes in all: 0xAAAA, 0x5555, 0xFFFF, 0x0000; then a walking one from 0x0001 up to 0x8000, rotating left one bit per pass; then a walking zero from 0xFFFE up to 0x7FFF, rotating left one bit per pass. Writes carry the current pattern on `mem_wdata_o`.
- R4: The word on `mem_rdata_i` one clock after a read request is compared with the pattern of that request's pass. The address it is paired with is the address of that request.
- R5: Each mismatch raises the error count by exactly one. The count saturates at all ones at its width (0xFFFF with the default 16 bits) and does not wrap.
- R6: After a run, `fail_addr_o`, `fail_rdata_o` and `fail_expect_o` hold the address, read word and expected word of the most recent mismatch. A run with no mismatch leaves them unchanged.
- R7: An accepted start clears the error count to zero.
- R8: `busy_o` is high from the cycle after an accepted start until the end of the run. `done_o` is high for exactly one cycle, two cycles after the last read request, when the count and record already include that read.
- R9: A `start_i` pulse while the engine is busy has no effect: the run in progress keeps its window and its result.
- R10: A window whose start equals its end tests that single word with one write and one read per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| win_lo_i | input | ADDR_W | First byte address of the window (word aligned) |
| win_hi_i | input | ADDR_W | Last byte address of the window, inclusive |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | DATA_W | Write data (current pattern) |
| mem_rdata_i | input | DATA_W | Read data, valid one clock after a read request |
| err_count_o | output | CNT_W | Saturating mismatch count |
| fail_addr_o | output | ADDR_W | Address of the most recent mismatch |
| fail_rdata_o | output | DATA_W | Word read at the most recent mismatch |
| fail_expect_o | output | DATA_W | Word expected at the most recent mismatch |

## Verification
The hardest situation to reach from the ports is a saturated error counter. One mismatch needs one read, so filling a 16-bit counter takes far more cycles than a short test allows. The bench therefore builds the engine with an 8-bit counter. It makes every word of a 16-word window hold bit 0 stuck at one, which gives 288 mismatches over one run and drives the count past its limit. A memory model injects stuck bits at one address or at all addresses. It predicts the count and the last-failure record from its own list of the 36 patterns.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  typedef enum logic [1:0] {
    K_FIXED = 2'd0,
    K_WALK1 = 2'd1,
    K_WALK0 = 2'd2
  } pat_kind_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FILL  = 2'd1,
    S_READ  = 2'd2,
    S_FLUSH = 2'd3
  } sweep_state_t;

  localparam int NUM_FIXED = 4;

endpackage

// File: rtl/mpt_sched.sv
module mpt_sched
  import mpt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [DATA_W-1:0] pattern,
  output logic              last_pass
);

  localparam int FIDX_W = $clog2(NUM_FIXED);
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(NUM_FIXED - 1);

  pat_kind_t         kind_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [DATA_W-1:0] pat_q;

  // Fixed pattern table: alternating bits (MSB set), its complement, ones, zeros.
  function automatic logic [DATA_W-1:0] fixed_pat(input logic [FIDX_W-1:0] idx);
    logic [DATA_W-1:0] alt;
    for (int b = 0; b < DATA_W; b++) alt[b] = b[0];
    case (idx)
      FIDX_W'(0): fixed_pat = alt;
      FIDX_W'(1): fixed_pat = ~alt;
      FIDX_W'(2): fixed_pat = '1;
      default:    fixed_pat = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rotl1(input logic [DATA_W-1:0] v);
    rotl1 = {v[DATA_W-2:0], v[DATA_W-1]};
  endfunction

  localparam logic [DATA_W-1:0] ONE_HOT0 = DATA_W'(1);

  // The walking-zero phase ends when the bit about to rotate out is a zero.
  assign last_pass = (kind_q == K_WALK0) && !pat_q[DATA_W-1];
  assign pattern   = pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_FIXED;
      fidx_q <= '0;
      pat_q  <= fixed_pat('0);
    end else if (restart) begin
      kind_q <= K_FIXED;
      fidx_q <= '0;
      pat_q  <= fixed_pat('0);
    end else if (advance) begin
      case (kind_q)
        K_FIXED: begin
          if (fidx_q == FIDX_LAST) begin
            kind_q <= K_WALK1;
            pat_q  <= ONE_HOT0;
          end else begin
            fidx_q <= fidx_q + 1'b1;
            pat_q  <= fixed_pat(fidx_q + 1'b1);
          end
        end
        K_WALK1: begin
          if (pat_q[DATA_W-1]) begin
            kind_q <= K_WALK0;
            pat_q  <= ~ONE_HOT0;
          end else begin
            pat_q <= rotl1(pat_q);
          end
        end
        default: pat_q <= rotl1(pat_q);
      endcase
    end
  end

  assert_walk1_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_WALK1) |-> ($countones(pat_q) == 1));

  assert_walk0_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_WALK0) |-> ($countones(~pat_q) == 1));

endmodule

// File: rtl/mpt_sweep.sv
module mpt_sweep
  import mpt_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic              last_pass,
  output logic              sched_restart,
  output logic              sched_advance,
  output logic              run_accept,
  output logic              rd_issue,
  output logic              busy,
  output logic              done,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  sweep_state_t      st_q;
  logic [ADDR_W-1:0] lo_q, hi_q, cur_q;
  logic              done_q;
  logic              at_end;

  assign at_end        = (cur_q == hi_q);
  assign run_accept    = (st_q == S_IDLE) && start;
  assign sched_restart = run_accept;
  assign sched_advance = (st_q == S_READ) && at_end && !last_pass;
  assign rd_issue      = (st_q == S_READ);
  assign req           = (st_q == S_FILL) || (st_q == S_READ);
  assign we            = (st_q == S_FILL);
  assign addr          = cur_q;
  assign busy          = (st_q != S_IDLE);
  assign done          = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      lo_q   <= '0;
      hi_q   <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == S_FLUSH);
      case (st_q)
        S_IDLE: if (start) begin
          lo_q  <= win_lo;
          hi_q  <= win_hi;
          cur_q <= win_lo;
          st_q  <= S_FILL;
        end
        S_FILL: begin
          if (at_end) begin
            cur_q <= lo_q;
            st_q  <= S_READ;
          end else begin
            cur_q <= cur_q + STEP;
          end
        end
        S_READ: begin
          if (at_end) begin
            cur_q <= lo_q;
            st_q  <= last_pass ? S_FLUSH : S_FILL;
          end else begin
            cur_q <= cur_q + STEP;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_addr_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (addr >= lo_q && addr <= hi_q));

  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/mpt_check.sv
module mpt_check #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_issue,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_expect,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  output logic [CNT_W-1:0]  err_cnt,
  output logic [ADDR_W-1:0] bad_addr,
  output logic [DATA_W-1:0] bad_rdata,
  output logic [DATA_W-1:0] bad_expect
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    sat_inc = (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  assign mismatch = vld_q && (rdata != exp_q);
  assign err_cnt  = cnt_q;

  // Read pipeline: address and expectation travel with the one-cycle read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else begin
      vld_q <= rd_issue;
      if (rd_issue) begin
        addr_q <= rd_addr;
        exp_q  <= rd_expect;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      bad_addr   <= '0;
      bad_rdata  <= '0;
      bad_expect <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (mismatch) begin
      cnt_q      <= sat_inc(cnt_q);
      bad_addr   <= addr_q;
      bad_rdata  <= rdata;
      bad_expect <= exp_q;
    end
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_count_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

  assert_mismatch_counted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clr) |=> (cnt_q != '0));

  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
  import mpt_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] win_lo_i,
  input  logic [ADDR_W-1:0] win_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  err_count_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_rdata_o,
  output logic [DATA_W-1:0] fail_expect_o
);

  // Internal events, named so assertions and waveforms can refer to them.
  logic              ev_restart;
  logic              ev_advance;
  logic              ev_accept;
  logic              ev_rd_issue;
  logic              ev_mismatch;
  logic              last_pass;
  logic [DATA_W-1:0] cur_pattern;

  mpt_sched #(.DATA_W(DATA_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ev_restart),
    .advance   (ev_advance),
    .pattern   (cur_pattern),
    .last_pass (last_pass)
  );

  mpt_sweep #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sweep (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_i),
    .win_lo        (win_lo_i),
    .win_hi        (win_hi_i),
    .last_pass     (last_pass),
    .sched_restart (ev_restart),
    .sched_advance (ev_advance),
    .run_accept    (ev_accept),
    .rd_issue      (ev_rd_issue),
    .busy          (busy_o),
    .done          (done_o),
    .req           (mem_req_o),
    .we            (mem_we_o),
    .addr          (mem_addr_o)
  );

  mpt_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ev_accept),
    .rd_issue   (ev_rd_issue),
    .rd_addr    (mem_addr_o),
    .rd_expect  (cur_pattern),
    .rdata      (mem_rdata_i),
    .mismatch   (ev_mismatch),
    .err_cnt    (err_count_o),
    .bad_addr   (fail_addr_o),
    .bad_rdata  (fail_rdata_o),
    .bad_expect (fail_expect_o)
  );

  assign mem_wdata_o = cur_pattern;

  assert_ignore_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ev_accept);

  assert_mismatch_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |-> $past(ev_rd_issue));

endmodule

// File: tb/sim_mem_pattern_tester.sv
`timescale 1ns/1ps
module sim_mem_pattern_tester;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NPASS = 36;

  typedef struct packed {
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic [AW-1:0] faddr;
    logic          all;
    logic [DW-1:0] s1;
    logic [DW-1:0] s0;
  } vec_t;

  // window, fault address, fault-on-all-words, stuck-at-1 mask, stuck-at-0 mask
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{20'h00100, 20'h0010E, 20'h00104, 1'b0, 16'h0010, 16'h0000},
    '{20'h00100, 20'h0010E, 20'h0010E, 1'b0, 16'h0000, 16'h8001},
    '{20'h00040, 20'h00040, 20'h00040, 1'b0, 16'h0000, 16'h0100},
    '{20'h00000, 20'h0001E, 20'h00000, 1'b1, 16'h0001, 16'h0000},
    '{20'h001F0, 20'h001FE, 20'h00000, 1'b0, 16'h0000, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] win_lo_i = '0;
  logic [AW-1:0] win_hi_i = '0;
  logic          busy_o, done_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i;
  logic [CW-1:0] err_count_o;
  logic [AW-1:0] fail_addr_o;
  logic [DW-1:0] fail_rdata_o, fail_expect_o;

  always #2 clk = ~clk;

  mem_pattern_tester #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_lo_i(win_lo_i), .win_hi_i(win_hi_i),
    .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .err_count_o(err_count_o), .fail_addr_o(fail_addr_o), .fail_rdata_o(fail_rdata_o),
    .fail_expect_o(fail_expect_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Fault configuration and memory model with one-cycle read latency.
  logic [AW-1:0] f_addr = '0;
  logic          f_all = 1'b0;
  logic [DW-1:0] f_s1 = '0, f_s0 = '0;
  logic [DW-1:0] mem [256];

  function automatic logic [DW-1:0] stored(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (f_all || a == f_addr) return (d | f_s1) & ~f_s0;
    return d;
  endfunction

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[8:1]] <= stored(mem_addr_o, mem_wdata_o);
      else          mem_rdata_i <= mem[mem_addr_o[8:1]];
    end
  end

  // Bench's own pattern list, built from the R3 wording.
  logic [DW-1:0] pats [NPASS];
  initial begin
    pats[0] = 16'hAAAA; pats[1] = 16'h5555; pats[2] = 16'hFFFF; pats[3] = 16'h0000;
    for (int i = 0; i < 16; i++) begin
      pats[4 + i]  = 16'h0001 << i;
      pats[20 + i] = ~(16'h0001 << i);
    end
  end

  // Access-trace monitor (R2, R3).
  logic          mon_en = 1'b0;
  logic [AW-1:0] mon_lo = '0;
  int            mon_n = 1;
  int            op_idx = 0;
  int            trace_err = 0;
  int            last_req_cyc = 0;

  always @(negedge clk) begin
    if (mon_en && mem_req_o) begin
      int pass, w;
      logic exp_we;
      logic [AW-1:0] exp_a;
      pass = op_idx / (2 * mon_n);
      w = op_idx % (2 * mon_n);
      exp_we = (w < mon_n);
      exp_a = mon_lo + AW'(2 * (w % mon_n));
      if (pass >= NPASS || mem_we_o !== exp_we || mem_addr_o !== exp_a ||
          (exp_we && mem_wdata_o !== pats[pass])) trace_err++;
      op_idx++;
      last_req_cyc = cyc;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected results kept by the bench (R5, R6).
  int            e_cnt;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_rd = '0, e_exp = '0;

  task automatic predict(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    int n;
    n = 0;
    for (int p = 0; p < NPASS; p++) begin
      for (logic [AW-1:0] a = lo; a <= hi; a += 2) begin
        logic [DW-1:0] s;
        s = stored(a, pats[p]);
        if (s != pats[p]) begin
          n++;
          e_addr = a; e_rd = s; e_exp = pats[p];
        end
      end
    end
    e_cnt = (n > MAXC) ? MAXC : n;
  endtask

  task automatic run_window(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input int poke);
    int wd, done_cyc;
    mon_lo = lo; mon_n = int'((hi - lo) / 2) + 1; op_idx = 0; trace_err = 0; mon_en = 1'b1;
    @(negedge clk);
    start_i = 1'b1; win_lo_i = lo; win_hi_i = hi;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 busy after start", {31'd0, busy_o}, 32'd1);
    wd = 0;
    while (!done_o && wd < 20000) begin
      @(negedge clk);
      wd++;
      if (poke > 0 && wd == poke) begin
        start_i = 1'b1; win_lo_i = 20'h00000; win_hi_i = 20'h00002;   // R9 stray start
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk("R8 done reached", {31'd0, done_o}, 32'd1);
    done_cyc = cyc;
    chk("R8 done two cycles after last read", done_cyc - last_req_cyc, 32'd2);
    chk("R2/R3 access trace errors", trace_err, 32'd0);
    chk("R2 access count", op_idx, NPASS * 2 * mon_n);
    mon_en = 1'b0;
    predict(lo, hi);
    chk("R5 error count", {24'd0, err_count_o}, e_cnt);
    chk("R6 last fail address", {12'd0, fail_addr_o}, {12'd0, e_addr});
    chk("R6 last fail read data", {16'd0, fail_rdata_o}, {16'd0, e_rd});
    chk("R6 last fail expected", {16'd0, fail_expect_o}, {16'd0, e_exp});
    @(negedge clk);
    chk("R8 done single cycle", {31'd0, done_o}, 32'd0);
    chk("R8 idle after done", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic check_idle_reset();
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 req", {31'd0, mem_req_o}, 32'd0);
    chk("R1 count", {24'd0, err_count_o}, 32'd0);
    chk("R1 fail addr", {12'd0, fail_addr_o}, 32'd0);
    chk("R1 fail data", {fail_rdata_o, fail_expect_o}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_reset();

    // Table walk: R2..R8, R10 (vector 2 is single-word), R5 saturation (vector 3), R7 (vector 4).
    for (int v = 0; v < NVEC; v++) begin
      f_addr = VECS[v].faddr; f_all = VECS[v].all; f_s1 = VECS[v].s1; f_s0 = VECS[v].s0;
      run_window(VECS[v].lo, VECS[v].hi, 0);
    end

    // R4: fault read values reach the compare; R9: stray start mid-run ignored.
    f_addr = 20'h00108; f_all = 1'b0; f_s1 = 16'h0000; f_s0 = 16'h0002;
    run_window(20'h00100, 20'h0010E, 40);

    // R10 directed: single word, clean, count cleared by start (R7).
    f_s0 = 16'h0000;
    run_window(20'h00080, 20'h00080, 0);
    chk("R10 single word clean count", {24'd0, err_count_o}, 32'd0);

    // R1: reset in the middle of a run returns to the idle state.
    f_all = 1'b1; f_s1 = 16'h0004;
    @(negedge clk);
    start_i = 1'b1; win_lo_i = 20'h00000; win_hi_i = 20'h0000E;
    @(negedge clk);
    start_i = 1'b0;
    repeat (300) @(negedge clk);
    chk("R5 counting during run", {31'd0, (err_count_o != 0)}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_reset();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule